// File: doc/BRIEF.md
# Torus Dimension-Order Route Computation

This block decides, for one switch of a two-dimensional torus with K nodes per ring, where the head flit of a packet goes next. It compares the destination coordinates in the header with the switch's own coordinates. It resolves the X dimension completely before it touches Y. Along each ring it moves the shorter way round. The answer is an output port code and a virtual channel number, and the buffers, crossbar and arbiters of the switch consume it.

Dimension-order routing by itself can deadlock on a ring, so any hop that uses a wrap-around link goes on virtual channel 1. The packet then stays on channel 1 for the remaining hops in that dimension. The unit computes this from the packet's source coordinate and its current position, so it keeps no per-packet state. When the packet turns into the next dimension, the channel drops back to 0. The decision depends only on the source, destination and current coordinates, never on traffic load.

The result is captured in a register on each head flit and held until the next head flit arrives.

Top module: `torus_dor_route`

## Requirements
- R1: In reset, and on the first cycle after reset, `route_port` is 0, `route_vc` is 0 and `route_valid` is 0.
- R2: When the destination X differs from the switch X, the port is X-bound: code 1 (+X) or 2 (-X), whatever the Y coordinates are.
- R3: When X matches and Y differs, the port is Y-bound: code 3 (+Y) or 4 (-Y).
- R4: The direction is the one with fewer hops. With forward distance f = (dst - self) mod K, the positive port is used when f < K/2 and the negative port when f > K/2.
- R5: When f equals exactly K/2, the positive port is chosen.
- R6: A hop that crosses the wrap-around link uses `route_vc` = 1. This is a positive hop leaving coordinate K-1, or a negative hop leaving coordinate 0.
- R7: A hop in a dimension in which the packet has already wrapped uses `route_vc` = 1. For positive travel, this means self < src in that dimension. For negative travel, it means self > src.
- R8: A hop in a dimension where the packet has not wrapped, including the first Y hop after a packet wrapped in X, uses `route_vc` = 0.
- R9: When both coordinates match, the port is 0 (local) and `route_vc` is 0.
- R10: The result for a head presented on `head_valid` in one cycle appears on the next cycle, with `route_valid` high for exactly that cycle. Outputs stay unchanged while `head_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | 1 | A head flit's coordinates are presented this cycle |
| src_x | input | CW | Source X coordinate from the header |
| src_y | input | CW | Source Y coordinate from the header |
| dst_x | input | CW | Destination X coordinate from the header |
| dst_y | input | CW | Destination Y coordinate from the header |
| self_x | input | CW | This switch's X coordinate |
| self_y | input | CW | This switch's Y coordinate |
| route_port | output | 3 | 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |
| route_vc | output | 1 | Virtual channel for this hop |
| route_valid | output | 1 | One-cycle pulse when a new route is presented |

## Verification
Two of the block's functions can meet in a single decision. The first is keeping X on channel 1 after a wrap. The second is falling back to channel 0 when the packet turns into Y. This is provoked with a header whose X has just been corrected after a wrap while its own Y wraps, or does not. The expected channel is judged per dimension against a step-by-step walk of the ring from the source. The capture of a new head can also coincide with the presentation of the previous result, so heads are issued on consecutive cycles. The scoreboard requires every pulse to carry the route of the matching head, in order.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;

    localparam int unsigned NUM_DIMS = 2;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_XNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_YNEG  = 3'd4
    } port_e;

    // Per-dimension verdict from one ring
    typedef struct packed {
        logic move;   // this dimension still needs correcting
        logic pos;    // travel in the positive direction
        logic vc;     // escape channel needed for the hop
    } dim_hint_t;

    typedef struct packed {
        port_e port;
        logic  vc;
    } route_t;

    // Port code for a given dimension and direction
    function automatic port_e dim_port(input int unsigned dim, input logic pos);
        logic [2:0] code;
        code = 3'(1 + 2 * dim + (pos ? 0 : 1));
        return port_e'(code);
    endfunction

endpackage

// File: rtl/torus_ring_dir.sv
module torus_ring_dir
    import torus_route_pkg::*;
#(
    parameter int unsigned K  = 4,
    parameter int unsigned CW = $clog2(K)
) (
    input  logic [CW-1:0] src,
    input  logic [CW-1:0] dst,
    input  logic [CW-1:0] here,
    output dim_hint_t     hint
);
    localparam logic [CW:0]   RING_W = (CW+1)'(K);
    localparam logic [CW:0]   HALF_W = (CW+1)'(K / 2);
    localparam logic [CW-1:0] LAST_C = CW'(K - 1);

    logic [CW:0] fwd;
    logic        going_pos;
    logic        passed_wrap;
    logic        on_wrap;

    always_comb begin
        if (dst >= here) begin
            fwd = {1'b0, dst} - {1'b0, here};
        end else begin
            fwd = {1'b0, dst} + RING_W - {1'b0, here};
        end
    end

    assign going_pos = (fwd <= HALF_W);

    always_comb begin
        if (going_pos) begin
            passed_wrap = (here < src);
            on_wrap     = (here == LAST_C);
        end else begin
            passed_wrap = (here > src);
            on_wrap     = (here == '0);
        end
    end

    always_comb begin
        hint.move = (fwd != '0);
        hint.pos  = going_pos;
        hint.vc   = hint.move && (passed_wrap || on_wrap);
    end

endmodule

// File: rtl/torus_port_select.sv
module torus_port_select
    import torus_route_pkg::*;
#(
    parameter int unsigned NDIM = NUM_DIMS
) (
    input  dim_hint_t hints [NDIM],
    output route_t    pick
);
    route_t stage [NDIM+1];

    assign stage[NDIM] = '{port: PORT_LOCAL, vc: 1'b0};

    // Lowest dimension that still moves wins: fixed correction order
    generate
        for (genvar d = NDIM - 1; d >= 0; d--) begin : g_order
            always_comb begin
                if (hints[d].move) begin
                    stage[d].port = dim_port(d, hints[d].pos);
                    stage[d].vc   = hints[d].vc;
                end else begin
                    stage[d] = stage[d+1];
                end
            end
        end
    endgenerate

    assign pick = stage[0];

endmodule

// File: rtl/torus_route_reg.sv
module torus_route_reg
    import torus_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  route_t next,
    output route_t held,
    output logic   fresh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '{port: PORT_LOCAL, vc: 1'b0};
            fresh <= 1'b0;
        end else begin
            fresh <= load;
            if (load) begin
                held <= next;
            end
        end
    end

endmodule

// File: rtl/torus_dor_route.sv
module torus_dor_route
    import torus_route_pkg::*;
#(
    parameter int unsigned K  = 4,
    parameter int unsigned CW = $clog2(K)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          head_valid,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] self_x,
    input  logic [CW-1:0] self_y,
    output logic [2:0]    route_port,
    output logic          route_vc,
    output logic          route_valid
);
    localparam int unsigned NDIM = NUM_DIMS;

    logic [CW-1:0] src_v  [NDIM];
    logic [CW-1:0] dst_v  [NDIM];
    logic [CW-1:0] self_v [NDIM];
    dim_hint_t     hints  [NDIM];
    route_t        comb_route;
    route_t        reg_route;

    assign src_v[0]  = src_x;
    assign src_v[1]  = src_y;
    assign dst_v[0]  = dst_x;
    assign dst_v[1]  = dst_y;
    assign self_v[0] = self_x;
    assign self_v[1] = self_y;

    generate
        for (genvar d = 0; d < NDIM; d++) begin : g_ring
            torus_ring_dir #(.K(K), .CW(CW)) ring_i (
                .src  (src_v[d]),
                .dst  (dst_v[d]),
                .here (self_v[d]),
                .hint (hints[d])
            );
        end
    endgenerate

    torus_port_select #(.NDIM(NDIM)) sel_i (
        .hints (hints),
        .pick  (comb_route)
    );

    torus_route_reg reg_i (
        .clk   (clk),
        .rst   (rst),
        .load  (head_valid),
        .next  (comb_route),
        .held  (reg_route),
        .fresh (route_valid)
    );

    assign route_port = reg_route.port;
    assign route_vc   = reg_route.vc;

endmodule

// File: rtl/torus_dor_route_chk.sv
module torus_dor_route_chk #(
    parameter int unsigned CW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          head_valid,
    input logic [CW-1:0] dst_x,
    input logic [CW-1:0] dst_y,
    input logic [CW-1:0] self_x,
    input logic [CW-1:0] self_y,
    input logic [2:0]    route_port,
    input logic          route_vc,
    input logic          route_valid
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_port == 3'd0 && !route_vc && !route_valid)); // R1

    AST_X_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($past(head_valid) && $past(dst_x != self_x))
        |-> (route_port == 3'd1 || route_port == 3'd2)); // R2

    AST_Y_SECOND: assert property (@(posedge clk) disable iff (rst)
        ($past(head_valid) && $past(dst_x == self_x) && $past(dst_y != self_y))
        |-> (route_port == 3'd3 || route_port == 3'd4)); // R3

    AST_LOCAL_DELIVER: assert property (@(posedge clk) disable iff (rst)
        ($past(head_valid) && $past(dst_x == self_x) && $past(dst_y == self_y))
        |-> (route_port == 3'd0 && !route_vc)); // R9

    AST_PULSE_TRACKS_HEAD: assert property (@(posedge clk) disable iff (rst)
        route_valid == $past(head_valid)); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(head_valid) |-> ($stable(route_port) && $stable(route_vc))); // R10

endmodule

bind torus_dor_route torus_dor_route_chk #(.CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .head_valid  (head_valid),
    .dst_x       (dst_x),
    .dst_y       (dst_y),
    .self_x      (self_x),
    .self_y      (self_y),
    .route_port  (route_port),
    .route_vc    (route_vc),
    .route_valid (route_valid)
);

// File: tb/torus_dor_route_tb_top.sv
`timescale 1ns/1ps
module torus_dor_route_tb_top;
    localparam int K  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          head_valid = 1'b0;
    logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
    logic [CW-1:0] self_x = '0, self_y = '0;
    logic [2:0]    route_port;
    logic          route_vc;
    logic          route_valid;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [2:0] port;
        logic       vc;
        string      tag;
    } exp_t;

    exp_t exp_q [$];
    exp_t last_exp;

    always #4 clk = ~clk;

    torus_dor_route #(.K(K), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .head_valid(head_valid),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .self_x(self_x), .self_y(self_y),
        .route_port(route_port), .route_vc(route_vc), .route_valid(route_valid)
    );

    // Independent model: walk the ring from the source and note wraps
    function automatic void dim_model(input int s, input int d, input int h,
                                      output logic pos, output logic vc);
        int f, p, steps;
        logic wrapped;
        f = (d - h + K) % K;
        pos = (2 * f <= K);
        wrapped = 1'b0;
        p = s;
        steps = 0;
        while (p != h && steps < K) begin
            if (pos) begin
                if (p == K - 1) wrapped = 1'b1;
                p = (p + 1) % K;
            end else begin
                if (p == 0) wrapped = 1'b1;
                p = (p + K - 1) % K;
            end
            steps++;
        end
        if (pos && h == K - 1) wrapped = 1'b1;
        if (!pos && h == 0) wrapped = 1'b1;
        vc = wrapped;
    endfunction

    function automatic exp_t model(input int sx, sy, dx, dy, hx, hy, input string tag);
        exp_t e;
        logic pos, vc;
        e.tag = tag;
        if (dx != hx) begin
            dim_model(sx, dx, hx, pos, vc);
            e.port = pos ? 3'd1 : 3'd2;
            e.vc = vc;
        end else if (dy != hy) begin
            dim_model(sy, dy, hy, pos, vc);
            e.port = pos ? 3'd3 : 3'd4;
            e.vc = vc;
        end else begin
            e.port = 3'd0;
            e.vc = 1'b0;
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: present one head for one cycle and push its expected route
    task automatic drive(input int sx, sy, dx, dy, hx, hy, input string tag);
        @(negedge clk);
        src_x = CW'(sx); src_y = CW'(sy);
        dst_x = CW'(dx); dst_y = CW'(dy);
        self_x = CW'(hx); self_y = CW'(hy);
        head_valid = 1'b1;
        exp_q.push_back(model(sx, sy, dx, dy, hx, hy, tag));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        head_valid = 1'b0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            // scramble the header while idle: must not affect outputs
            dst_x = CW'(i); dst_y = CW'(i + 1); self_x = CW'(i + 2);
        end
    endtask

    // Monitor: pop and compare every route pulse
    always @(negedge clk) begin
        if (!rst && route_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R10 actual=unexpected_pulse expected=none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                last_exp = e;
                check({e.tag, " port"}, {1'b0, route_port}, {1'b0, e.port});
                check({e.tag, " vc"}, {3'b0, route_vc}, {3'b0, e.vc});
            end
        end
    end

    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset port", {1'b0, route_port}, 4'd0);
        check("R1 reset vc/valid", {2'b0, route_vc, route_valid}, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {route_port, route_valid}, 4'd0);

        drive(1, 2, 3, 3, 3, 3, "R9 local");
        drive(0, 0, 1, 2, 0, 0, "R2 R4 X plus with Y differing");
        drive(1, 0, 0, 0, 1, 0, "R4 X minus");
        drive(0, 0, 2, 0, 0, 0, "R5 X tie");
        drive(3, 1, 1, 1, 3, 1, "R5 R6 X tie on wrap");
        idle(2);
        drive(3, 0, 0, 0, 3, 0, "R6 X plus wrap");
        drive(0, 2, 3, 2, 0, 2, "R6 X minus wrap");
        drive(3, 0, 1, 0, 0, 0, "R7 X after wrap");
        drive(3, 0, 1, 1, 1, 0, "R8 R3 turn into Y after X wrap");
        drive(2, 3, 2, 0, 2, 3, "R6 Y plus wrap");
        drive(2, 1, 2, 0, 2, 1, "R3 Y minus");
        drive(0, 2, 0, 0, 0, 3, "R6 Y wrap from mid path");
        drive(0, 3, 0, 1, 0, 0, "R7 Y after wrap");
        drive(1, 0, 1, 2, 1, 1, "R8 Y ordinary");
        drive(3, 2, 1, 0, 1, 3, "R7 R8 Y wrapped after X wrap");
        idle(5);

        // R10: after idle with scrambled header, outputs still hold the last route
        check("R10 hold port", {1'b0, route_port}, {1'b0, last_exp.port});
        check("R10 hold vc", {3'b0, route_vc}, {3'b0, last_exp.vc});
        check("R10 no pulse when idle", {3'b0, route_valid}, 4'd0);
        check("R10 queue drained", 4'(exp_q.size()), 4'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule